// File: doc/BRIEF.md
# Dual-Bank Colour Matrix (3x4 Gamut Remap)

This block multiplies a stream of RGB pixels by a 3x4 colour matrix. Each output channel is a weighted sum of the three input channels plus a constant offset. The result is rounded and clamped to the unsigned pixel range. A write-only register port loads two complete coefficient sets, A and B, and sets a mode and a coefficient format. A `cur_mode` status output shows which set is currently in use.

Software updates the matrix without a visible glitch. It loads the set that is not in use, requests that set in the mode register, and the switch happens at the next frame-start strobe. Pixels of the frame in flight therefore never see a half-written matrix. In the coefficient format register, 0 selects signed Q2.13 and 1 selects signed Q3.12. Software writes the format before the coefficients that use it.

Top module: `cmx_remap`

## Requirements
- R1: Register address 0 is the mode request and address 1 the format (bit 0). Addresses 2..7 hold set A and 8..13 hold set B, with two coefficients per 32-bit word. Word k of a set (k = 0..5) puts coefficient 2k in bits 15:0 and coefficient 2k+1 in bits 31:16. Coefficients are numbered row-major, so index 4*row + col, where row 0..2 maps to R, G, B out and col 0..3 maps to R, G, B in and the offset.
- R2: Mode codes (bits 1:0 of a write to address 0) are 0 for bypass, 1 for set A and 2 for set B. A write of the reserved code 3 is ignored and leaves the requested mode unchanged.
- R3: A requested mode takes effect only at a clock edge where `frame_start` is high, and `cur_mode` changes at that edge. A pixel sampled at that same edge still uses the previous mode.
- R4: With format 0, each channel is round((c0*R + c1*G + c2*B + c3*2^PIX_W) / 2^13) for that row's coefficients c0..c3. The coefficients are signed 16-bit two's complement.
- R5: With format 1, the same sum is divided by 2^12 instead.
- R6: The fourth coefficient of a row is a constant offset scaled by 2^PIX_W before division, so 1.0 adds full scale plus one code.
- R7: Rounding adds half an output code before an arithmetic right shift (round half up), so 0.5 rounds to 1 and 1.5 rounds to 2.
- R8: Results below zero give 0, and results above 2^PIX_W-1 give 2^PIX_W-1.
- R9: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and each output pixel appears two cycles after its input.
- R10: In bypass mode each output channel equals the matching input channel, delayed by two cycles.
- R11: Writes to the set that is not selected do not change the outputs computed with the selected set.
- R12: After reset, `cur_mode` is 0, `out_valid` is 0, the requested mode and format are 0, and all coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary strobe; applies the requested mode |
| cur_mode | output | 2 | Mode currently in use |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | PIX_W | Red in |
| in_g | input | PIX_W | Green in |
| in_b | input | PIX_W | Blue in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Red out |
| out_g | output | PIX_W | Green out |
| out_b | output | PIX_W | Blue out |

## Verification
The bench builds the block with PIX_W = 8 and ADDR_W = 4. With 8-bit pixels, random coefficients drive the sum past 255 and below zero often, so both clamp limits are hit many times. Offsets of a quarter scale move a channel by exactly 64 codes, which makes offset and packing errors easy to see. Random valid gaps, bank swaps at frame strobes and switches between formats mid-stream test latency, bank isolation and the Q2.13/Q3.12 shift against a model that keeps the requested mode and the active mode apart.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SET_A  = 2'd1,
    MODE_SET_B  = 2'd2,
    MODE_RSVD   = 2'd3
  } cmx_mode_e;

  localparam int unsigned COEF_W      = 16;
  localparam int unsigned ROWS        = 3;
  localparam int unsigned COLS        = 4;
  localparam int unsigned NUM_COEF    = ROWS * COLS;
  localparam int unsigned PAIRS       = NUM_COEF / 2;
  localparam int unsigned ADDR_MODE   = 0;
  localparam int unsigned ADDR_FMT    = 1;
  localparam int unsigned ADDR_BANK_A = 2;
  localparam int unsigned ADDR_BANK_B = ADDR_BANK_A + PAIRS;
  localparam int unsigned FRAC_FMT0   = 13;
  localparam int unsigned FRAC_FMT1   = 12;
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
  import cmx_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [2*COEF_W-1:0]          wr_data,
  output logic [NUM_COEF*COEF_W-1:0]   coef_a,
  output logic [NUM_COEF*COEF_W-1:0]   coef_b
);
  logic [NUM_COEF*COEF_W-1:0] store [2];

  for (genvar bk = 0; bk < 2; bk++) begin : g_bank
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int unsigned WORD_ADDR = (bk == 0 ? ADDR_BANK_A : ADDR_BANK_B) + p;
      logic [2*COEF_W-1:0] pair_q;
      always_ff @(posedge clk) begin
        if (rst) pair_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(WORD_ADDR)) pair_q <= wr_data;
      end
      // low half holds the even-numbered coefficient of the pair
      assign store[bk][p*2*COEF_W +: 2*COEF_W] = pair_q;
    end
  end

  assign coef_a = store[0];
  assign coef_b = store[1];
endmodule

// File: rtl/cmx_mode_ctrl.sv
module cmx_mode_ctrl
  import cmx_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_low,
  input  logic              frame_start,
  output cmx_mode_e         active_mode,
  output logic              fmt_alt
);
  cmx_mode_e pending_q, active_q;
  logic      fmt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= MODE_BYPASS;
      fmt_q     <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_MODE) && cmx_mode_e'(wr_low) != MODE_RSVD)
        pending_q <= cmx_mode_e'(wr_low);
      if (wr_addr == ADDR_W'(ADDR_FMT))
        fmt_q <= wr_low[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              active_q <= MODE_BYPASS;
    else if (frame_start) active_q <= pending_q;
  end

  assign active_mode = active_q;
  assign fmt_alt     = fmt_q;

  // R2
  reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADDR_MODE) && wr_low == 2'd3) |=> $stable(pending_q));
  // R2
  no_reserved_active_chk: assert property (@(posedge clk) disable iff (rst)
    active_q != MODE_RSVD);
  // R3
  mode_holds_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(active_q));
endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
#(
  parameter int unsigned PIX_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [COLS*COEF_W-1:0]   coef,
  input  logic                     fmt_alt,
  input  logic                     bypass,
  input  logic [PIX_W-1:0]         pix_r,
  input  logic [PIX_W-1:0]         pix_g,
  input  logic [PIX_W-1:0]         pix_b,
  input  logic [PIX_W-1:0]         pix_own,
  output logic [PIX_W-1:0]         res
);
  localparam int unsigned PROD_W = COEF_W + PIX_W + 1;
  localparam int unsigned ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] RND0 = ACC_W'(1) <<< (FRAC_FMT0 - 1);
  localparam logic signed [ACC_W-1:0] RND1 = ACC_W'(1) <<< (FRAC_FMT1 - 1);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

  logic [PIX_W-1:0]          pix_v  [3];
  logic signed [PROD_W-1:0]  prod_d [3];
  logic signed [PROD_W-1:0]  prod_q [3];
  logic signed [ACC_W-1:0]   off_d, off_q, sum, rounded, shifted;
  logic                      fmt_q1, byp_q1;
  logic [PIX_W-1:0]          own_q1, res_d;

  assign pix_v[0] = pix_r;
  assign pix_v[1] = pix_g;
  assign pix_v[2] = pix_b;

  for (genvar k = 0; k < 3; k++) begin : g_mul
    assign prod_d[k] = PROD_W'($signed(coef[k*COEF_W +: COEF_W]))
                     * PROD_W'($signed({1'b0, pix_v[k]}));
  end
  assign off_d = ACC_W'($signed(coef[3*COEF_W +: COEF_W])) <<< PIX_W;

  // stage 1: products and offset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 3; k++) prod_q[k] <= '0;
      off_q  <= '0;
      fmt_q1 <= 1'b0;
      byp_q1 <= 1'b0;
      own_q1 <= '0;
    end else begin
      for (int k = 0; k < 3; k++) prod_q[k] <= prod_d[k];
      off_q  <= off_d;
      fmt_q1 <= fmt_alt;
      byp_q1 <= bypass;
      own_q1 <= pix_own;
    end
  end

  // stage 2: sum, round, clamp
  always_comb begin
    sum     = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2]) + off_q;
    rounded = sum + (fmt_q1 ? RND1 : RND0);
    shifted = fmt_q1 ? (rounded >>> FRAC_FMT1) : (rounded >>> FRAC_FMT0);
    if (byp_q1)              res_d = own_q1;
    else if (shifted[ACC_W-1]) res_d = '0;
    else if (shifted > MAXV) res_d = '1;
    else                     res_d = shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else     res <= res_d;
  end
endmodule

// File: rtl/cmx_remap.sv
module cmx_remap
  import cmx_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              frame_start,
  output logic [1:0]        cur_mode,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  logic [NUM_COEF*COEF_W-1:0] coef_a, coef_b, coef_sel;
  cmx_mode_e                  active_mode;
  logic                       fmt_alt, vld_q1, vld_q2;
  logic [PIX_W-1:0]           pix_in [ROWS];
  logic [PIX_W-1:0]           pix_out[ROWS];

  cmx_coef_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .coef_a(coef_a), .coef_b(coef_b)
  );

  cmx_mode_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_low(wr_data[1:0]),
    .frame_start(frame_start), .active_mode(active_mode), .fmt_alt(fmt_alt)
  );

  assign coef_sel  = (active_mode == MODE_SET_B) ? coef_b : coef_a;
  assign pix_in[0] = in_r;
  assign pix_in[1] = in_g;
  assign pix_in[2] = in_b;

  for (genvar row = 0; row < ROWS; row++) begin : g_row
    cmx_row #(.PIX_W(PIX_W)) u_row (
      .clk(clk), .rst(rst),
      .coef(coef_sel[row*COLS*COEF_W +: COLS*COEF_W]),
      .fmt_alt(fmt_alt), .bypass(active_mode == MODE_BYPASS),
      .pix_r(in_r), .pix_g(in_g), .pix_b(in_b), .pix_own(pix_in[row]),
      .res(pix_out[row])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q1 <= 1'b0;
      vld_q2 <= 1'b0;
    end else begin
      vld_q1 <= in_valid;
      vld_q2 <= vld_q1;
    end
  end

  assign cur_mode  = active_mode;
  assign out_valid = vld_q2;
  assign out_r     = pix_out[0];
  assign out_g     = pix_out[1];
  assign out_b     = pix_out[2];

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R10
  bypass_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_mode == 2'd0) |-> ##2 (out_g == $past(in_g, 2)));
endmodule

// File: tb/cmx_remap_bench.sv
module cmx_remap_bench;
  localparam int PW = 8;
  localparam int AW = 4;
  localparam int MAXP = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, frame_start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [PW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic [1:0] cur_mode;
  logic out_valid;
  logic [PW-1:0] out_r, out_g, out_b;

  always #4 clk = ~clk;

  cmx_remap #(.PIX_W(PW), .ADDR_W(AW)) u_cmx_remap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .cur_mode(cur_mode), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic signed [15:0] m_a[12], m_b[12], stage[12];
  int m_pend = 0, m_act = 0, m_fmt = 0;

  // drive staging
  logic d_wr = 0, d_fs = 0, d_vld = 0;
  logic [AW-1:0] d_addr = '0;
  logic [31:0] d_data = '0;
  int d_r = 0, d_g = 0, d_b = 0;
  string tag = "R9";

  // expectation pipe
  logic v0 = 0, v1 = 0;
  int e0[3], e1[3];
  string t0 = "", t1 = "";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_ch(input int row, input int r, input int g, input int b);
    longint c[4];
    longint acc;
    int f;
    int px[3];
    px[0] = r; px[1] = g; px[2] = b;
    if (m_act == 0) return px[row];
    for (int k = 0; k < 4; k++) c[k] = (m_act == 2) ? longint'(m_b[4*row+k]) : longint'(m_a[4*row+k]);
    f = (m_fmt == 1) ? 12 : 13;
    acc = c[0]*r + c[1]*g + c[2]*b + c[3]*(64'sd1 << PW);
    acc = acc + (64'sd1 << (f-1));
    acc = acc >>> f;
    if (acc < 0) return 0;
    if (acc > MAXP) return MAXP;
    return int'(acc);
  endfunction

  task automatic tick();
    @(negedge clk);
    check(out_valid == v1, "R9", int'(out_valid), int'(v1));
    if (v1) begin
      check(out_r == PW'(e1[0]), t1, int'(out_r), e1[0]);
      check(out_g == PW'(e1[1]), t1, int'(out_g), e1[1]);
      check(out_b == PW'(e1[2]), t1, int'(out_b), e1[2]);
    end
    v1 = v0; e1 = e0; t1 = t0;
    v0 = d_vld; t0 = tag;
    for (int k = 0; k < 3; k++) e0[k] = model_ch(k, d_r, d_g, d_b);
    wr_en = d_wr; wr_addr = d_addr; wr_data = d_data; frame_start = d_fs;
    in_valid = d_vld; in_r = PW'(d_r); in_g = PW'(d_g); in_b = PW'(d_b);
    if (d_fs) m_act = m_pend;
    if (d_wr) begin
      if (d_addr == 0 && d_data[1:0] != 2'd3) m_pend = int'(d_data[1:0]);
      if (d_addr == 1) m_fmt = int'(d_data[0]);
      if (d_addr >= 2 && d_addr < 8) begin
        m_a[2*(d_addr-2)] = d_data[15:0]; m_a[2*(d_addr-2)+1] = d_data[31:16];
      end
      if (d_addr >= 8 && d_addr < 14) begin
        m_b[2*(d_addr-8)] = d_data[15:0]; m_b[2*(d_addr-8)+1] = d_data[31:16];
      end
    end
    d_wr = 0; d_fs = 0; d_vld = 0;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    d_wr = 1; d_addr = AW'(addr); d_data = data; tick();
  endtask

  task automatic load(input int bank);
    for (int p = 0; p < 6; p++) wr((bank == 2 ? 8 : 2) + p, {stage[2*p+1], stage[2*p]});
  endtask

  task automatic clear_stage();
    for (int k = 0; k < 12; k++) stage[k] = 16'sd0;
  endtask

  task automatic pix(input int r, input int g, input int b);
    d_vld = 1; d_r = r; d_g = g; d_b = b; tick();
  endtask

  task automatic stream(input int n, input int gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps != 0 && ($urandom % 4) == 0) tick();
      else pix($urandom % (MAXP+1), $urandom % (MAXP+1), $urandom % (MAXP+1));
    end
  endtask

  task automatic switch_to(input int mode);
    wr(0, 32'(mode));
    d_fs = 1; tick();
    tick();
    check(int'(cur_mode) == m_act, "R3", int'(cur_mode), m_act);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 12; k++) begin m_a[k] = 0; m_b[k] = 0; end
    repeat (4) @(negedge clk);
    check(cur_mode == 2'd0, "R12", int'(cur_mode), 0);
    check(out_valid == 1'b0, "R12", int'(out_valid), 0);
    rst = 1'b0;

    tag = "R10"; stream(30, 1);

    // R3: mode request alone does nothing until the frame strobe
    wr(0, 32'd1);
    tick();
    check(cur_mode == 2'd0, "R3", int'(cur_mode), 0);
    d_fs = 1; tick();
    tick();
    check(cur_mode == 2'd1, "R3", int'(cur_mode), 1);
    tag = "R12"; stream(8, 0);  // reset coefficients give zero

    // R11: load idle set B with random values while A stays active
    for (int k = 0; k < 12; k++) stage[k] = 16'($urandom);
    load(2);
    tag = "R11"; stream(10, 0);

    tag = "R4"; switch_to(2); stream(40, 1);
    wr(1, 32'd1); tag = "R5"; stream(40, 1);

    // R7: half-code rounding with 0.5 gain in Q2.13
    wr(1, 32'd0);
    clear_stage(); stage[0] = 16'sd4096; load(1);
    tag = "R7"; switch_to(1);
    pix(1, 0, 0); pix(3, 0, 0); pix(2, 0, 0); pix(0, 0, 0);

    // R6, R8: unity diagonal with +/- quarter-scale offsets
    clear_stage(); stage[0] = 16'sd8192; stage[5] = 16'sd8192; stage[10] = 16'sd8192;
    stage[3] = 16'sd2048; stage[7] = -16'sd2048;
    load(2);
    tag = "R6"; switch_to(2);
    pix(10, 100, 5); pix(100, 64, 0);
    tag = "R8"; pix(250, 10, 255); pix(191, 63, 0);

    // R1: off-diagonal placement inside packed words
    clear_stage(); stage[1] = 16'sd8192; stage[6] = 16'sd4096; stage[11] = 16'sd1024;
    load(1);
    tag = "R1"; switch_to(1);
    pix(7, 200, 90); pix(0, 33, 255); stream(10, 0);

    // R2: reserved code ignored, bypass restored
    wr(0, 32'd3); d_fs = 1; tick(); tick();
    check(cur_mode == 2'd1, "R2", int'(cur_mode), 1);
    tag = "R2"; stream(6, 0);
    switch_to(0);
    check(cur_mode == 2'd0, "R2", int'(cur_mode), 0);
    tag = "R10"; stream(10, 0);

    // R8: random large coefficients in both formats, alternating sets
    for (int it = 0; it < 6; it++) begin
      for (int k = 0; k < 12; k++) stage[k] = 16'($urandom);
      load((it % 2 == 0) ? 1 : 2);
      wr(1, 32'(it % 3 == 0));
      tag = "R8"; switch_to((it % 2 == 0) ? 1 : 2);
      stream(60, 1);
    end

    tick(); tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule